// File: doc/BRIEF.md
# Indirect Dword Window Register File

This block holds the working registers of a slot hot-plug controller as a byte-addressable file. Every byte carries two fixed per-byte masks: a write-enable mask, and a write-one-to-clear mask whose set bits never overlap the write-enable mask. Bits outside both masks are read-only from software. A hardware set port lets the controller logic raise status or event bits. The block does not interpret register contents. It only raises a strobe when the command field has been written.

Software reaches the file in two ways. The direct port takes little-endian accesses of 1 to 4 bytes. The indirect window is an 8-byte structure. Its select byte sits at window offset 2 and its 32-bit data register at offsets 4 to 7. A window write that overlaps the data register is forwarded as a 4-byte write to working address select*4. After every window write, the data register is reloaded from the file at select*4. The size of the file is 0x24 + 4 * NUM_SLOTS bytes. The per-slot dword at 0x24 + 4*s holds a 2-byte status field, then the event latch byte, then the event disable byte.

Top module: `dword_window_regfile`

## Requirements
- R1: A direct write updates each written byte as new = (old AND NOT wmask) OR (data AND wmask). Bits outside both masks keep their value. Write masks: offset 0x14 bits 7:0, offset 0x15 bits 4:0, offset 0x20 bits 3:0, and byte 3 of each slot dword (0x27, 0x2B, ...) bits 6:0. All other bytes have a write mask of zero.
- R2: Write-one-to-clear bits are offset 0x22 bits 1:0 and byte 2 of each slot dword (0x26, 0x2A, ...) bits 4:0. Writing 1 to such a bit clears it. Writing 0 leaves it unchanged.
- R3: The hardware set port ORs hw_bits_i into the byte at hw_addr_i, regardless of masks. When it lands in the same cycle as a software write to that byte, the set bits survive. A set at or beyond the file size has no effect.
- R4: After reset, every byte is zero except these: 0x04 = NUM_SLOTS, 0x0C = NUM_SLOTS, 0x0D = 0x01, 0x0E = 0x01, 0x0F = 0xE0, 0x13 = 0x01, 0x20 = 0x0F. In each slot dword, byte 0 = 0x0F, byte 1 = 0x0D and byte 3 = 0x7F.
- R5: A direct read of length 1 to 4 returns the bytes addr..addr+len-1 little-endian in dir_rdata_o, with dir_rvalid_o high in the following cycle only. Unused upper lanes read zero.
- R6: Bytes at or beyond the file size read as zero and ignore writes. An access that crosses the end is trimmed to the bytes inside.
- R7: The window select byte (window offset 2) and data register (offsets 4 to 7) are fully writable. Window offsets 0, 1 and 3 ignore writes and read zero. Window reads return data in the following cycle with win_rvalid_o high.
- R8: A window write that touches any of offsets 4 to 7 is forwarded, through the masks, as a 4-byte write of the updated data register to working address select*4. If the same access also writes the select byte, the new select value is used.
- R9: After every window write, the data register holds the 4 file bytes at select*4 as they stand after that cycle's updates. Bytes beyond the file read as zero.
- R10: cmd_wr_o pulses high for one cycle after any direct or forwarded write that covers offset 0x14 or 0x15. No other write raises it.
- R11: After reset, the window select is 0 and the data register is 0.
- R12: Direct writes and hardware sets do not change the window data register. It stays stale until the next window write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_req_i | input | 1 | Direct access request |
| dir_we_i | input | 1 | Direct access is a write |
| dir_addr_i | input | AW | Direct byte address |
| dir_len_i | input | 3 | Direct access length, 1 to 4 bytes |
| dir_wdata_i | input | 32 | Direct write data, little-endian |
| dir_rdata_o | output | 32 | Direct read data |
| dir_rvalid_o | output | 1 | Direct read data valid |
| win_req_i | input | 1 | Window access request (never in the same cycle as dir_req_i) |
| win_we_i | input | 1 | Window access is a write |
| win_addr_i | input | 3 | Byte offset inside the window |
| win_len_i | input | 3 | Window access length, 1 to 4 bytes |
| win_wdata_i | input | 32 | Window write data |
| win_rdata_o | output | 32 | Window read data |
| win_rvalid_o | output | 1 | Window read data valid |
| hw_set_i | input | 1 | Hardware bit-set request |
| hw_addr_i | input | AW | Byte address for the hardware set |
| hw_bits_i | input | 8 | Bits to set |
| cmd_wr_o | output | 1 | Command field written |

## Verification
The hardest situation to reach is the stale window data register. Direct writes and hardware sets change the dword that the window points at, yet leave the window's copy untouched. Only a later window write, even one aimed at an ignored window byte, brings the copy back in step. The stimulus first aims the window at the command dword. It then rewrites that dword directly, reads the window to see the old value, and finally writes window offset 0 to force a reload. Partial window writes that span both the select byte and the data register are also driven. They show that the forward goes to the new select address and carries the old upper data bytes.

// File: rtl/ridw_pkg.sv
package ridw_pkg;
  localparam int unsigned SLOT_BASE   = 'h24;
  localparam int unsigned CMD_CODE    = 'h14;
  localparam int unsigned CMD_TGT     = 'h15;
  localparam int unsigned IRQ_CTL     = 'h20;
  localparam int unsigned WIN_BYTES   = 8;
  localparam int unsigned WIN_SEL_OFS = 2;
  localparam int unsigned WIN_DAT_OFS = 4;

  function automatic int unsigned file_bytes(int unsigned nslots);
    return SLOT_BASE + 4 * nslots;
  endfunction

  function automatic bit in_slots(int unsigned a, int unsigned nslots);
    return (a >= SLOT_BASE) && (a < file_bytes(nslots));
  endfunction

  function automatic logic [7:0] wmask_of(int unsigned a, int unsigned nslots);
    if (a == CMD_CODE) return 8'hFF;
    if (a == CMD_TGT) return 8'h1F;
    if (a == IRQ_CTL) return 8'h0F;
    if (in_slots(a, nslots) && (a % 4) == 3) return 8'h7F;
    return 8'h00;
  endfunction

  function automatic logic [7:0] w1c_of(int unsigned a, int unsigned nslots);
    if (a == IRQ_CTL + 2) return 8'h03;
    if (in_slots(a, nslots) && (a % 4) == 2) return 8'h1F;
    return 8'h00;
  endfunction

  function automatic logic [7:0] rst_of(int unsigned a, int unsigned nslots);
    if (in_slots(a, nslots)) begin
      case (a % 4)
        0:       return 8'h0F;
        1:       return 8'h0D;
        3:       return 8'h7F;
        default: return 8'h00;
      endcase
    end
    case (a)
      'h04, 'h0C: return 8'(nslots);
      'h0D, 'h0E, 'h13: return 8'h01;
      'h0F:       return 8'hE0;
      'h20:       return 8'h0F;
      default:    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ridw_byte_cell.sv
module ridw_byte_cell #(
  parameter logic [7:0] WMASK   = 8'h00,
  parameter logic [7:0] W1CMASK = 8'h00,
  parameter logic [7:0] RSTVAL  = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_byte_i,
  input  logic [7:0] set_i,
  output logic [7:0] q_o,
  output logic [7:0] nxt_o
);
  localparam logic [7:0] FIXED = ~(WMASK | W1CMASK);

  logic [7:0] q;

  always_comb begin
    nxt_o = q;
    if (wr_en_i) begin
      nxt_o = (q & ~WMASK) | (wr_byte_i & WMASK);
      nxt_o = nxt_o & ~(wr_byte_i & W1CMASK);
    end
    nxt_o = nxt_o | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RSTVAL;
    else         q <= nxt_o;
  end

  assign q_o = q;

  assert_fixed_bits_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == 8'h00) |=> ((q & FIXED) == ($past(q) & FIXED)));

  assert_w1c_no_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == 8'h00) |=> ((q & W1CMASK & ~$past(q)) == 8'h00));
endmodule

// File: rtl/ridw_file.sv
module ridw_file
  import ridw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned IAW       = 11,
  localparam int unsigned NB       = file_bytes(NUM_SLOTS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [IAW-1:0]  wr_addr_i,
  input  logic [2:0]      wr_len_i,
  input  logic [31:0]     wr_data_i,
  input  logic            set_en_i,
  input  logic [IAW-1:0]  set_addr_i,
  input  logic [7:0]      set_bits_i,
  output logic [NB*8-1:0] q_flat_o,
  output logic [NB*8-1:0] nxt_flat_o
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic       hit;
    logic [7:0] lane;
    logic [7:0] set;

    always_comb begin
      int off;
      off  = b - int'(wr_addr_i);
      hit  = wr_en_i && (off >= 0) && (off < int'(wr_len_i));
      lane = wr_data_i[8*(off & 3) +: 8];
      set  = (set_en_i && (int'(set_addr_i) == b)) ? set_bits_i : 8'h00;
    end

    ridw_byte_cell #(
      .WMASK  (wmask_of(b, NUM_SLOTS)),
      .W1CMASK(w1c_of(b, NUM_SLOTS)),
      .RSTVAL (rst_of(b, NUM_SLOTS))
    ) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (hit),
      .wr_byte_i(lane),
      .set_i    (set),
      .q_o      (q_flat_o[8*b +: 8]),
      .nxt_o    (nxt_flat_o[8*b +: 8])
    );
  end
endmodule

// File: rtl/ridw_window.sv
module ridw_window
  import ridw_pkg::*;
#(
  parameter logic [31:0] RST_DATA = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [2:0]  len_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] reload_i,
  output logic [7:0]  sel_nxt_o,
  output logic        fwd_en_o,
  output logic [31:0] fwd_data_o,
  output logic        touch_o,
  output logic [7:0]  sel_o,
  output logic [31:0] data_o,
  output logic [31:0] rdata_o,
  output logic        rvalid_o
);
  logic [7:0]  sel_q;
  logic [31:0] data_q;
  logic [31:0] rd_nxt;
  logic [63:0] view;

  assign touch_o = req_i && we_i;
  assign view    = {data_q, 8'h00, sel_q, 16'h0000};

  always_comb begin
    int idx;
    idx        = 0;
    sel_nxt_o  = sel_q;
    fwd_data_o = data_q;
    fwd_en_o   = 1'b0;
    rd_nxt     = 32'h0;
    for (int k = 0; k < 4; k++) begin
      idx = int'(addr_i) + k;
      if (k < int'(len_i) && idx < WIN_BYTES) begin
        rd_nxt[8*k +: 8] = view[8*idx +: 8];
        if (touch_o) begin
          if (idx == WIN_SEL_OFS) begin
            sel_nxt_o = wdata_i[8*k +: 8];
          end else if (idx >= WIN_DAT_OFS) begin
            fwd_data_o[8*(idx-WIN_DAT_OFS) +: 8] = wdata_i[8*k +: 8];
            fwd_en_o = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= 8'h00;
      data_q   <= RST_DATA;
      rdata_o  <= 32'h0;
      rvalid_o <= 1'b0;
    end else begin
      if (touch_o) begin
        sel_q  <= sel_nxt_o;
        data_q <= reload_i;
      end
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_nxt;
    end
  end

  assign sel_o  = sel_q;
  assign data_o = data_q;

  assert_sel_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(sel_o));

  assert_data_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(data_o));
endmodule

// File: rtl/dword_window_regfile.sv
module dword_window_regfile
  import ridw_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned AW        = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_req_i,
  input  logic          dir_we_i,
  input  logic [AW-1:0] dir_addr_i,
  input  logic [2:0]    dir_len_i,
  input  logic [31:0]   dir_wdata_i,
  output logic [31:0]   dir_rdata_o,
  output logic          dir_rvalid_o,
  input  logic          win_req_i,
  input  logic          win_we_i,
  input  logic [2:0]    win_addr_i,
  input  logic [2:0]    win_len_i,
  input  logic [31:0]   win_wdata_i,
  output logic [31:0]   win_rdata_o,
  output logic          win_rvalid_o,
  input  logic          hw_set_i,
  input  logic [AW-1:0] hw_addr_i,
  input  logic [7:0]    hw_bits_i,
  output logic          cmd_wr_o
);
  localparam int unsigned NB  = file_bytes(NUM_SLOTS);
  localparam int unsigned IAW = ((AW > 10) ? AW : 10) + 1;
  localparam logic [31:0] RST_DW0 = {rst_of(3, NUM_SLOTS), rst_of(2, NUM_SLOTS),
                                     rst_of(1, NUM_SLOTS), rst_of(0, NUM_SLOTS)};

  logic [NB*8-1:0] q_flat, nxt_flat;
  logic [7:0]      sel_nxt, sel;
  logic            fwd_en, win_touch;
  logic [31:0]     fwd_data, win_data, reload, win_mirror;
  logic            wr_en;
  logic [IAW-1:0]  wr_addr;
  logic [2:0]      wr_len;
  logic [31:0]     wr_data;
  logic            cmd_hit;

  function automatic logic [31:0] pick(input logic [NB*8-1:0] flat,
                                       input int unsigned a, input int unsigned n);
    logic [31:0] r;
    r = 32'h0;
    for (int k = 0; k < 4; k++) begin
      if (k < n && (a + k) < NB) r[8*k +: 8] = flat[8*(a+k) +: 8];
    end
    return r;
  endfunction

  // forwarded window write wins the file port; callers keep the ports exclusive
  always_comb begin
    if (fwd_en) begin
      wr_en   = 1'b1;
      wr_addr = IAW'({sel_nxt, 2'b00});
      wr_len  = 3'd4;
      wr_data = fwd_data;
    end else begin
      wr_en   = dir_req_i && dir_we_i;
      wr_addr = IAW'(dir_addr_i);
      wr_len  = dir_len_i;
      wr_data = dir_wdata_i;
    end
    cmd_hit = wr_en && (int'(wr_addr) <= CMD_TGT)
              && ((int'(wr_addr) + int'(wr_len)) > CMD_CODE);
  end

  assign reload     = pick(nxt_flat, {sel_nxt, 2'b00}, 4);
  assign win_mirror = pick(q_flat, {sel, 2'b00}, 4);

  ridw_file #(.NUM_SLOTS(NUM_SLOTS), .IAW(IAW)) u_file (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_len_i  (wr_len),
    .wr_data_i (wr_data),
    .set_en_i  (hw_set_i),
    .set_addr_i(IAW'(hw_addr_i)),
    .set_bits_i(hw_bits_i),
    .q_flat_o  (q_flat),
    .nxt_flat_o(nxt_flat)
  );

  ridw_window #(.RST_DATA(RST_DW0)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (win_req_i),
    .we_i      (win_we_i),
    .addr_i    (win_addr_i),
    .len_i     (win_len_i),
    .wdata_i   (win_wdata_i),
    .reload_i  (reload),
    .sel_nxt_o (sel_nxt),
    .fwd_en_o  (fwd_en),
    .fwd_data_o(fwd_data),
    .touch_o   (win_touch),
    .sel_o     (sel),
    .data_o    (win_data),
    .rdata_o   (win_rdata_o),
    .rvalid_o  (win_rvalid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_rdata_o  <= 32'h0;
      dir_rvalid_o <= 1'b0;
      cmd_wr_o     <= 1'b0;
    end else begin
      dir_rvalid_o <= dir_req_i && !dir_we_i;
      if (dir_req_i && !dir_we_i) dir_rdata_o <= pick(q_flat, dir_addr_i, dir_len_i);
      cmd_wr_o <= cmd_hit;
    end
  end

  assert_rvalid_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_req_i && !dir_we_i) |=> dir_rvalid_o);

  assert_rvalid_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_rvalid_o |-> $past(dir_req_i && !dir_we_i));

  assert_oob_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_req_i && !dir_we_i && (int'(dir_addr_i) >= NB)) |=> (dir_rdata_o == 32'h0));

  assert_reload_mirror_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_touch |=> (win_data == win_mirror));

  assert_cmd_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_o |-> $past(wr_en));
endmodule

// File: tb/dword_window_regfile_bench.sv
`timescale 1ns/1ps
module dword_window_regfile_bench;
  localparam int NS = 4;
  localparam int FB = 36 + 4 * NS;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dir_req_i = 0, dir_we_i = 0, win_req_i = 0, win_we_i = 0, hw_set_i = 0;
  logic [7:0]  dir_addr_i = 0, hw_addr_i = 0, hw_bits_i = 0;
  logic [2:0]  dir_len_i = 0, win_addr_i = 0, win_len_i = 0;
  logic [31:0] dir_wdata_i = 0, win_wdata_i = 0;
  logic [31:0] dir_rdata_o, win_rdata_o;
  logic        dir_rvalid_o, win_rvalid_o, cmd_wr_o;

  always #10 clk = ~clk;

  dword_window_regfile #(.NUM_SLOTS(NS), .AW(8)) u_dword_window_regfile (
    .clk_i(clk), .rst_ni(rst_ni),
    .dir_req_i(dir_req_i), .dir_we_i(dir_we_i), .dir_addr_i(dir_addr_i),
    .dir_len_i(dir_len_i), .dir_wdata_i(dir_wdata_i), .dir_rdata_o(dir_rdata_o),
    .dir_rvalid_o(dir_rvalid_o),
    .win_req_i(win_req_i), .win_we_i(win_we_i), .win_addr_i(win_addr_i),
    .win_len_i(win_len_i), .win_wdata_i(win_wdata_i), .win_rdata_o(win_rdata_o),
    .win_rvalid_o(win_rvalid_o),
    .hw_set_i(hw_set_i), .hw_addr_i(hw_addr_i), .hw_bits_i(hw_bits_i),
    .cmd_wr_o(cmd_wr_o)
  );

  // reference model state
  logic [7:0]  mem [FB];
  logic [7:0]  m_sel;
  logic [31:0] m_data;
  logic        exp_rv = 0, exp_wrv = 0, exp_cmd = 0;
  logic [31:0] exp_rd = 0, exp_wrd = 0;
  int          n_chk = 0, n_fail = 0;
  string       cur_req = "R4";
  bit          chk_on = 0, done = 0;

  // pending stimulus for the next cycle
  bit          p_dr, p_dw, p_wr, p_ww, p_hs;
  int          p_da, p_dl, p_wa, p_wl, p_ha;
  logic [31:0] p_dd, p_wd;
  logic [7:0]  p_hb;

  function automatic logic [7:0] b_wm(int a);
    if (a == 'h14) return 8'hFF;
    if (a == 'h15) return 8'h1F;
    if (a == 'h20) return 8'h0F;
    if (a >= 36 && a < FB && (a - 36) % 4 == 3) return 8'h7F;
    return 8'h00;
  endfunction

  function automatic logic [7:0] b_w1(int a);
    if (a == 'h22) return 8'h03;
    if (a >= 36 && a < FB && (a - 36) % 4 == 2) return 8'h1F;
    return 8'h00;
  endfunction

  function automatic logic [7:0] b_rst(int a);
    if (a >= 36 && a < FB) begin
      case ((a - 36) % 4)
        0: return 8'h0F;
        1: return 8'h0D;
        3: return 8'h7F;
        default: return 8'h00;
      endcase
    end
    if (a == 'h04 || a == 'h0C) return 8'(NS);
    if (a == 'h0D || a == 'h0E || a == 'h13) return 8'h01;
    if (a == 'h0F) return 8'hE0;
    if (a == 'h20) return 8'h0F;
    return 8'h00;
  endfunction

  function automatic logic [31:0] m_pick(int a, int l);
    logic [31:0] r = 0;
    for (int k = 0; k < 4; k++)
      if (k < l && a + k < FB) r[8*k +: 8] = mem[a+k];
    return r;
  endfunction

  task automatic m_write(int a, int l, logic [31:0] d);
    for (int k = 0; k < l; k++) begin
      int x = a + k;
      if (x < FB) begin
        logic [7:0] b = d[8*k +: 8];
        mem[x] = (mem[x] & ~b_wm(x)) | (b & b_wm(x));
        mem[x] = mem[x] & ~(b & b_w1(x));
        if (x == 'h14 || x == 'h15) exp_cmd = 1;
      end
    end
  endtask

  task automatic step();
    bit touch = 0;
    @(negedge clk);
    dir_req_i = p_dr; dir_we_i = p_dw; dir_addr_i = 8'(p_da); dir_len_i = 3'(p_dl);
    dir_wdata_i = p_dd;
    win_req_i = p_wr; win_we_i = p_ww; win_addr_i = 3'(p_wa); win_len_i = 3'(p_wl);
    win_wdata_i = p_wd;
    hw_set_i = p_hs; hw_addr_i = 8'(p_ha); hw_bits_i = p_hb;
    exp_rv = 0; exp_wrv = 0; exp_cmd = 0;
    if (p_dr && !p_dw) begin exp_rv = 1; exp_rd = m_pick(p_da, p_dl); end
    if (p_dr && p_dw) m_write(p_da, p_dl, p_dd);
    if (p_wr) begin
      logic [63:0] view = {m_data, 8'h00, m_sel, 16'h0000};
      logic [31:0] nd = m_data;
      bit fwd = 0;
      for (int k = 0; k < p_wl; k++) begin
        int i = p_wa + k;
        if (i < 8) begin
          if (!p_ww) exp_wrd[8*k +: 8] = view[8*i +: 8];
          else if (i == 2) m_sel = p_wd[8*k +: 8];
          else if (i >= 4) begin nd[8*(i-4) +: 8] = p_wd[8*k +: 8]; fwd = 1; end
        end
      end
      if (!p_ww) begin
        for (int k = p_wl; k < 4; k++) exp_wrd[8*k +: 8] = 8'h00;
        for (int k = 0; k < 4; k++) if (p_wa + k >= 8) exp_wrd[8*k +: 8] = 8'h00;
        exp_wrv = 1;
      end else begin
        touch = 1;
        if (fwd) m_write(int'(m_sel) * 4, 4, nd);
      end
    end
    if (p_hs && p_ha < FB) mem[p_ha] = mem[p_ha] | p_hb;
    if (touch) m_data = m_pick(int'(m_sel) * 4, 4);
    p_dr = 0; p_dw = 0; p_wr = 0; p_ww = 0; p_hs = 0;
  endtask

  task automatic drd(int a, int l); p_dr = 1; p_da = a; p_dl = l; step(); endtask
  task automatic dwr(int a, int l, logic [31:0] d);
    p_dr = 1; p_dw = 1; p_da = a; p_dl = l; p_dd = d; step();
  endtask
  task automatic wrd(int a, int l); p_wr = 1; p_wa = a; p_wl = l; step(); endtask
  task automatic wwr(int a, int l, logic [31:0] d);
    p_wr = 1; p_ww = 1; p_wa = a; p_wl = l; p_wd = d; step();
  endtask
  task automatic hset(int a, logic [7:0] b); p_hs = 1; p_ha = a; p_hb = b; step(); endtask
  task automatic dwr_hset(int a, int l, logic [31:0] d, int ha, logic [7:0] hb);
    p_dr = 1; p_dw = 1; p_da = a; p_dl = l; p_dd = d;
    p_hs = 1; p_ha = ha; p_hb = hb; step();
  endtask
  task automatic idle(); step(); endtask

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // compare with the model on every clock, a quarter period after the edge
  always begin
    @(posedge clk);
    #5;
    if (chk_on && !done) begin
      chk("dir_rvalid", 32'(dir_rvalid_o), 32'(exp_rv));
      if (exp_rv) chk("dir_rdata", dir_rdata_o, exp_rd);
      chk("win_rvalid", 32'(win_rvalid_o), 32'(exp_wrv));
      if (exp_wrv) chk("win_rdata", win_rdata_o, exp_wrd);
      chk("cmd_wr", 32'(cmd_wr_o), 32'(exp_cmd));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    p_dr = 0; p_dw = 0; p_wr = 0; p_ww = 0; p_hs = 0;
    p_da = 0; p_dl = 0; p_wa = 0; p_wl = 0; p_ha = 0; p_dd = 0; p_wd = 0; p_hb = 0;
    for (int i = 0; i < FB; i++) mem[i] = b_rst(i);
    m_sel = 0; m_data = m_pick(0, 4);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk_on = 1;

    cur_req = "R4";
    for (int a = 0; a < FB; a += 4) drd(a, 4);
    cur_req = "R11";
    wrd(0, 4); wrd(4, 4);

    cur_req = "R5";
    dwr(20, 2, 32'h0000_0a37); drd(20, 1); drd(21, 1); drd(19, 3); drd(18, 2);
    dwr(32, 4, 32'h0000_0005); drd(32, 4);

    cur_req = "R1";
    dwr(12, 4, 32'hffff_ffff); drd(12, 4);
    dwr(21, 1, 32'hff); drd(20, 2);
    dwr(39, 1, 32'hff); drd(36, 4);
    dwr(32, 1, 32'hf3); drd(32, 4);

    cur_req = "R2";
    hset(38, 8'h1f); drd(36, 4);
    dwr(38, 1, 32'h05); drd(36, 4);
    dwr(38, 1, 32'h00); drd(36, 4);
    hset(34, 8'h03); drd(32, 4);
    dwr(32, 4, 32'h0001_0000); drd(32, 4);

    cur_req = "R3";
    hset(42, 8'h04); drd(40, 4);
    dwr_hset(42, 1, 32'h1f, 42, 8'h10); drd(40, 4);
    hset(36, 8'h40); drd(36, 4);
    hset(60, 8'hff); drd(48, 4);

    cur_req = "R6";
    drd(48, 4); drd(50, 4); drd(51, 2); drd(52, 4); drd(128, 4); drd(255, 4);
    dwr(51, 4, 32'hffff_ffff); drd(48, 4);
    dwr(200, 4, 32'hffff_ffff); drd(0, 4); drd(20, 4);

    cur_req = "R7";
    wwr(2, 1, 32'h05); wrd(0, 4); wrd(2, 1);
    wwr(0, 2, 32'hffff); wrd(0, 4);
    wwr(3, 1, 32'hff); wrd(0, 4);

    cur_req = "R9";
    wrd(4, 4);
    wwr(2, 1, 32'hc8); wrd(4, 4);
    wwr(2, 1, 32'h0c); wrd(4, 4);

    cur_req = "R8";
    wwr(2, 1, 32'h05); wwr(4, 4, 32'h0000_1f48); wrd(4, 4); drd(20, 4);
    wwr(2, 1, 32'h09); hset(38, 8'h1f);
    wwr(4, 4, 32'hffff_ffff); wrd(4, 4); drd(36, 4);
    wwr(2, 4, 32'h1f04_000a); drd(40, 4); wrd(0, 4); wrd(4, 4);
    wwr(6, 4, 32'h0000_ffff); wrd(4, 4); drd(40, 4);

    cur_req = "R12";
    wwr(2, 1, 32'h05); dwr(20, 1, 32'h11); hset(23, 8'h80); wrd(4, 4); drd(20, 4);
    wwr(0, 1, 32'h00); wrd(4, 4);

    cur_req = "R10";
    dwr(22, 2, 32'hffff); dwr(19, 1, 32'hff); dwr(18, 3, 32'hffffff);
    dwr(21, 1, 32'h0); dwr(16, 4, 32'h0); idle();
    wwr(2, 1, 32'h04); wwr(4, 1, 32'h00);
    wwr(2, 1, 32'h06); wwr(4, 4, 32'h0); drd(20, 4);

    idle(); idle();
    finish_run();
  end
endmodule